// File: doc/BRIEF.md
# Frame Alignment Loss Monitor

This block sits behind a T1 or E1 receive framer that has already found alignment. Each time the framer checks a framing bit, a frame alignment word or a CRC submultiframe, it strobes the block with the result. The block judges those results against a programmable criterion. When the criterion is met, it declares loss of frame alignment. The declaration appears as a one-clock alarm pulse and as a status flag that stays set until the framer reports new alignment.

The criterion is chosen by a line-mode select and a 4-bit code. In T1 mode the block runs a sliding-window test: two F-bit errors among the last 4, 5 or 6 F-bits checked. In E1 mode it counts consecutive frame alignment word errors. It can also count CRC submultiframe errors inside a one-second window of 1000 submultiframes. The all-zero code turns monitoring off and also withdraws permission for the alarm-indication status. Every other code is invalid. An invalid code behaves like the off setting and raises a flag.

Any change of mode or code wipes all history, and no declaration can happen in that cycle. A declaration also restarts all history.

Top module: `falign_monitor`

## Requirements
- R1: While reset (rstN low) is held, lossPulse and lossStatus are 0.
- R2: With modeE1=0 and critCode=4'b0001, a fbitStb whose result makes 2 of the last 4 F-bit results errors raises lossPulse in the cycle after that strobe. Two errors separated by three correct F-bits do not raise it. FAS strobes have no effect in T1 mode.
- R3: With modeE1=0, critCode=4'b0010 uses a window of the last 5 F-bit results and critCode=4'b0100 uses a window of the last 6. Errors farther apart than the window do not declare.
- R4: With modeE1=1 and critCode=4'b1100, the third consecutive fasStb with fasErr=1 declares. A fasStb with fasErr=0 resets the run. F-bit and CRC strobes have no effect.
- R5: With modeE1=1 and critCode=4'b0100, the block declares on 3 consecutive FAS errors. It also declares on the 915th crcErr counted in a window of 1000 crcStb events. The error count and the window restart every 1000 crcStb events.
- R6: A declaration restarts all history, so the next declaration needs a complete fresh criterion.
- R7: critCode=4'b0000 in either mode gives no lossPulse, forces lossStatus to 0, and drives aisEnable=0 and cfgInvalid=0.
- R8: Any mode/code pair not listed in R2 to R5, and not zero, drives cfgInvalid=1 and aisEnable=0 and gives no lossPulse. The valid pairs drive aisEnable=1 and cfgInvalid=0.
- R9: In a cycle where {modeE1, critCode} differs from the previous cycle, no declaration occurs and all history is cleared, including any strobe in that cycle.
- R10: lossPulse lasts one cycle. lossStatus is set with it and stays set until realign=1 or monitoring is turned off. A realign cycle clears history and suppresses any declaration in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeE1 | input | 1 | Line mode: 1 = E1, 0 = T1 |
| critCode | input | 4 | Loss criterion code |
| fbitStb | input | 1 | An F-bit was checked this cycle |
| fbitErr | input | 1 | That F-bit was in error |
| fasStb | input | 1 | A frame alignment word was checked this cycle |
| fasErr | input | 1 | That word was in error |
| crcStb | input | 1 | A CRC submultiframe was checked this cycle |
| crcErr | input | 1 | That CRC check failed |
| realign | input | 1 | Framer reports new alignment; clears status and history |
| lossPulse | output | 1 | One-cycle loss-of-alignment alarm |
| lossStatus | output | 1 | Sticky loss-of-alignment flag |
| aisEnable | output | 1 | Alarm-indication status reporting permitted |
| cfgInvalid | output | 1 | Mode/code pair is invalid |

## Verification
The bench tests where each window ends. It sends two T1 errors placed just inside and just outside the 4, 5 and 6 slot windows. A design with the wrong window width either misses the declaration or raises a false one.

It sends a good FAS word between FAS errors, and it sends 914 CRC errors followed by a clean window rollover. A design that does not reset the run or the one-second window declares one strobe too early.

It changes the configuration, and asserts realign, in cycles that also carry a strobe that would otherwise declare. A design that fails to suppress the declaration or wipe history alarms early. It also drives the off code and invalid codes while sending error strobes. A design that decodes them as live criteria alarms, or leaves the sticky flag set.

// File: rtl/fam_pkg.sv
package fam_pkg;

  typedef enum logic [1:0] {
    KIND_OFF,
    KIND_T1_WIN,
    KIND_E1_FAS,
    KIND_E1_BOTH
  } critKind_t;

  typedef struct packed {
    logic      clearAll;
    critKind_t kind;
    logic [3:0] winLen;
  } ctlStrobes_t;

endpackage

// File: rtl/fam_ctrl.sv
module fam_ctrl
  import fam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeE1,
  input  logic [3:0]  critCode,
  input  logic        realign,
  input  logic        declareReq,
  output ctlStrobes_t ctl,
  output logic        lossPulse,
  output logic        lossStatus,
  output logic        aisEnable,
  output logic        cfgInvalid
);

  critKind_t  kind;
  logic [3:0] winLen;
  logic       active;
  logic [4:0] cfgNow;
  logic [4:0] cfgPrev;
  logic       cfgChange;
  logic       fire;

  // Criterion decode
  always_comb begin
    kind   = KIND_OFF;
    winLen = 4'd0;
    if (modeE1) begin
      case (critCode)
        4'b0100: kind = KIND_E1_BOTH;
        4'b1100: kind = KIND_E1_FAS;
        default: kind = KIND_OFF;
      endcase
    end else begin
      case (critCode)
        4'b0001: begin kind = KIND_T1_WIN; winLen = 4'd4; end
        4'b0010: begin kind = KIND_T1_WIN; winLen = 4'd5; end
        4'b0100: begin kind = KIND_T1_WIN; winLen = 4'd6; end
        default: kind = KIND_OFF;
      endcase
    end
  end

  assign active     = (kind != KIND_OFF);
  assign aisEnable  = active;
  assign cfgInvalid = (critCode != 4'b0000) && !active;
  assign cfgNow     = {modeE1, critCode};
  assign cfgChange  = (cfgNow != cfgPrev);
  assign fire       = declareReq && active && !cfgChange && !realign;

  assign ctl.clearAll = !active || cfgChange || realign;
  assign ctl.kind     = kind;
  assign ctl.winLen   = winLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPrev    <= '0;
      lossPulse  <= 1'b0;
      lossStatus <= 1'b0;
    end else begin
      cfgPrev   <= cfgNow;
      lossPulse <= fire;
      if (!active || realign)
        lossStatus <= 1'b0;
      else if (fire)
        lossStatus <= 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |=> !lossPulse); // R10
  AST_STATUS_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |-> lossStatus); // R10
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lossStatus && !realign && active) |=> lossStatus); // R10
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!lossPulse && !lossStatus)); // R7
  AST_QUIET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    cfgChange |=> !lossPulse); // R9
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgInvalid |=> !lossPulse); // R8

endmodule

// File: rtl/fam_datapath.sv
module fam_datapath
  import fam_pkg::*;
#(
  parameter int HIST_DEPTH = 6,
  parameter int ERR_THRESH = 2,
  parameter int FAS_LIMIT  = 3,
  parameter int CRC_LIMIT  = 915,
  parameter int CRC_WINDOW = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        fbitStb,
  input  logic        fbitErr,
  input  logic        fasStb,
  input  logic        fasErr,
  input  logic        crcStb,
  input  logic        crcErr,
  output logic        declareReq
);

  localparam int CNT_W  = $clog2(HIST_DEPTH + 1);
  localparam int FAS_W  = $clog2(FAS_LIMIT + 1);
  localparam int CERR_W = $clog2(CRC_LIMIT + 1);
  localparam int CSUB_W = $clog2(CRC_WINDOW + 1);

  logic [HIST_DEPTH-1:0] hist;
  logic [HIST_DEPTH-1:0] histNext;
  logic [HIST_DEPTH-1:0] winMask;
  logic [HIST_DEPTH-1:0] masked;
  logic [CNT_W-1:0]      fbitSum;
  logic [FAS_W-1:0]      fasCnt;
  logic [CERR_W-1:0]     crcErrCnt;
  logic [CSUB_W-1:0]     crcSubCnt;
  logic t1On, fasOn, crcOn;
  logic t1Hit, fasHit, crcHit, restart;

  // Window mask: the newest winLen history slots
  for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_mask
    assign winMask[g] = (ctl.winLen > 4'(g));
  end

  assign histNext = {hist[HIST_DEPTH-2:0], fbitErr};
  assign masked   = histNext & winMask;

  always_comb begin
    fbitSum = '0;
    for (int i = 0; i < HIST_DEPTH; i++)
      fbitSum = fbitSum + {{(CNT_W-1){1'b0}}, masked[i]};
  end

  assign t1On  = (ctl.kind == KIND_T1_WIN);
  assign fasOn = (ctl.kind == KIND_E1_FAS) || (ctl.kind == KIND_E1_BOTH);
  assign crcOn = (ctl.kind == KIND_E1_BOTH);

  assign t1Hit  = t1On && fbitStb && (fbitSum >= CNT_W'(ERR_THRESH));
  assign fasHit = fasOn && fasStb && fasErr && (fasCnt == FAS_W'(FAS_LIMIT - 1));
  assign crcHit = crcOn && crcStb && crcErr && (crcErrCnt == CERR_W'(CRC_LIMIT - 1));

  assign declareReq = t1Hit || fasHit || crcHit;
  assign restart    = ctl.clearAll || declareReq;

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      hist      <= '0;
      fasCnt    <= '0;
      crcErrCnt <= '0;
      crcSubCnt <= '0;
    end else begin
      if (t1On && fbitStb)
        hist <= histNext;
      if (fasOn && fasStb)
        fasCnt <= fasErr ? fasCnt + 1'b1 : '0;
      if (crcOn && crcStb) begin
        if (crcSubCnt == CSUB_W'(CRC_WINDOW - 1)) begin
          crcSubCnt <= '0;
          crcErrCnt <= '0;
        end else begin
          crcSubCnt <= crcSubCnt + 1'b1;
          crcErrCnt <= crcErrCnt + {{(CERR_W-1){1'b0}}, crcErr};
        end
      end
    end
  end

  AST_FAS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    fasCnt < FAS_W'(FAS_LIMIT)); // R4
  AST_CRC_ERR_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    crcErrCnt < CERR_W'(CRC_LIMIT)); // R5
  AST_CRC_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    crcSubCnt < CSUB_W'(CRC_WINDOW)); // R5
  AST_HIST_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rstN)
    (t1On && !ctl.clearAll) |-> ($countones(hist & winMask) < ERR_THRESH)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (hist == '0 && fasCnt == '0 && crcErrCnt == '0)); // R9

endmodule

// File: rtl/falign_monitor.sv
module falign_monitor
  import fam_pkg::*;
#(
  parameter int HIST_DEPTH = 6,
  parameter int ERR_THRESH = 2,
  parameter int FAS_LIMIT  = 3,
  parameter int CRC_LIMIT  = 915,
  parameter int CRC_WINDOW = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeE1,
  input  logic [3:0] critCode,
  input  logic       fbitStb,
  input  logic       fbitErr,
  input  logic       fasStb,
  input  logic       fasErr,
  input  logic       crcStb,
  input  logic       crcErr,
  input  logic       realign,
  output logic       lossPulse,
  output logic       lossStatus,
  output logic       aisEnable,
  output logic       cfgInvalid
);

  ctlStrobes_t ctl;
  logic        declareReq;

  fam_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeE1     (modeE1),
    .critCode   (critCode),
    .realign    (realign),
    .declareReq (declareReq),
    .ctl        (ctl),
    .lossPulse  (lossPulse),
    .lossStatus (lossStatus),
    .aisEnable  (aisEnable),
    .cfgInvalid (cfgInvalid)
  );

  fam_datapath #(
    .HIST_DEPTH (HIST_DEPTH),
    .ERR_THRESH (ERR_THRESH),
    .FAS_LIMIT  (FAS_LIMIT),
    .CRC_LIMIT  (CRC_LIMIT),
    .CRC_WINDOW (CRC_WINDOW)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .fbitStb    (fbitStb),
    .fbitErr    (fbitErr),
    .fasStb     (fasStb),
    .fasErr     (fasErr),
    .crcStb     (crcStb),
    .crcErr     (crcErr),
    .declareReq (declareReq)
  );

endmodule

// File: tb/falign_monitor_test.sv
module falign_monitor_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeE1 = 1'b0;
  logic [3:0] critCode = 4'b0001;
  logic fbitStb = 0, fbitErr = 0, fasStb = 0, fasErr = 0;
  logic crcStb = 0, crcErr = 0, realign = 0;
  logic lossPulse, lossStatus, aisEnable, cfgInvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  falign_monitor uut (
    .clk(clk), .rstN(rstN), .modeE1(modeE1), .critCode(critCode),
    .fbitStb(fbitStb), .fbitErr(fbitErr), .fasStb(fasStb), .fasErr(fasErr),
    .crcStb(crcStb), .crcErr(crcErr), .realign(realign),
    .lossPulse(lossPulse), .lossStatus(lossStatus),
    .aisEnable(aisEnable), .cfgInvalid(cfgInvalid)
  );

  typedef struct {
    bit    p;
    bit    s;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit expStatus = 0;
  bit nextMode = 0;
  logic [3:0] nextCode = 4'b0001;

  function automatic bit cfgValid(bit m, logic [3:0] c);
    if (m) return (c == 4'b0100) || (c == 4'b1100);
    return (c == 4'b0001) || (c == 4'b0010) || (c == 4'b0100);
  endfunction

  task automatic checkBit(logic act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(bit fb, bit fe, bit fa, bit fae, bit cr, bit cre,
                      bit rl, bit expP, string tag);
    @(negedge clk);
    modeE1 = nextMode; critCode = nextCode;
    fbitStb = fb; fbitErr = fe; fasStb = fa; fasErr = fae;
    crcStb = cr; crcErr = cre; realign = rl;
    if (!cfgValid(nextMode, nextCode) || rl) expStatus = 0;
    else if (expP) expStatus = 1;
    sb.push_back('{expP, expStatus, tag});
  endtask

  task automatic fb(bit e, bit p, string t);  step(1, e, 0, 0, 0, 0, 0, p, t); endtask
  task automatic fa(bit e, bit p, string t);  step(0, 0, 1, e, 0, 0, 0, p, t); endtask
  task automatic cr(bit e, bit p, string t);  step(0, 0, 0, 0, 1, e, 0, p, t); endtask
  task automatic idle(string t);              step(0, 0, 0, 0, 0, 0, 0, 0, t); endtask
  task automatic rlg(string t);               step(0, 0, 0, 0, 0, 0, 1, 0, t); endtask

  task automatic setCfg(bit m, logic [3:0] c, bit expInv, bit expAis, string t);
    nextMode = m; nextCode = c;
    idle(t);
    #1;
    checkBit(cfgInvalid, expInv, {t, " cfgInvalid"});
    checkBit(aisEnable, expAis, {t, " aisEnable"});
  endtask

  // Monitor: compare outputs one step after each active edge
  initial begin
    forever begin : mon
      exp_t e;
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checkBit(lossPulse, e.p, {e.tag, " lossPulse"});
        checkBit(lossStatus, e.s, {e.tag, " lossStatus"});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkBit(lossPulse, 0, "R1 reset pulse");
    checkBit(lossStatus, 0, "R1 reset status");
    @(negedge clk) rstN = 1'b1;
    idle("R1 first cycle");

    // R2: 2 of last 4
    fb(1, 0, "R2"); fb(0, 0, "R2"); fb(0, 0, "R2"); fb(0, 0, "R2");
    fb(1, 0, "R2 outside window"); fb(1, 1, "R2 declare");
    idle("R10 status holds");
    rlg("R10 realign clears status");
    // R6: restart after declaration
    fb(1, 0, "R6"); fb(1, 1, "R6 declare");
    fb(1, 0, "R6 restarted"); fb(1, 1, "R6 declare again");
    fa(1, 0, "R2 fas ignored"); fa(1, 0, "R2 fas ignored"); fa(1, 0, "R2 fas ignored");
    // R10: realign suppresses a would-be declaration
    fb(1, 0, "R10");
    step(1, 1, 0, 0, 0, 0, 1, 0, "R10 realign suppresses");
    fb(1, 0, "R10 history cleared"); fb(1, 1, "R10 declare");

    // R3: window 5
    setCfg(0, 4'b0010, 0, 1, "R3 cfg 5");
    fb(1, 0, "R3"); fb(0, 0, "R3"); fb(0, 0, "R3"); fb(0, 0, "R3"); fb(0, 0, "R3");
    fb(1, 0, "R3 span 6 in window 5");
    fb(0, 0, "R3"); fb(0, 0, "R3"); fb(1, 1, "R3 window 5 declare");
    // R3: window 6
    setCfg(0, 4'b0100, 0, 1, "R3 cfg 6");
    fb(1, 0, "R3"); fb(0, 0, "R3"); fb(0, 0, "R3"); fb(0, 0, "R3"); fb(0, 0, "R3");
    fb(1, 1, "R3 window 6 declare");
    fb(1, 0, "R3"); for (int i = 0; i < 5; i++) fb(0, 0, "R3");
    fb(1, 0, "R3 span 7 in window 6");

    // R4: consecutive FAS only
    setCfg(1, 4'b1100, 0, 1, "R4 cfg");
    fa(1, 0, "R4"); fa(1, 0, "R4"); fa(0, 0, "R4 good resets");
    fa(1, 0, "R4"); fa(1, 0, "R4"); fa(1, 1, "R4 declare");
    fb(1, 0, "R4 fbit ignored"); fb(1, 0, "R4 fbit ignored");
    for (int i = 0; i < 915; i++) cr(1, 0, "R4 crc ignored");

    // R5: FAS or CRC
    setCfg(1, 4'b0100, 0, 1, "R5 cfg");
    fa(1, 0, "R5"); fa(1, 0, "R5"); fa(1, 1, "R5 fas declare");
    for (int i = 0; i < 914; i++) cr(1, 0, "R5 crc count");
    cr(1, 1, "R5 crc declare");
    for (int i = 0; i < 914; i++) cr(1, 0, "R5 window");
    for (int i = 0; i < 86; i++) cr(0, 0, "R5 window");
    cr(1, 0, "R5 window restarted");

    // R7: off
    setCfg(0, 4'b0000, 0, 0, "R7 off T1");
    fb(1, 0, "R7"); fb(1, 0, "R7");
    setCfg(1, 4'b0000, 0, 0, "R7 off E1");
    fa(1, 0, "R7"); fa(1, 0, "R7"); fa(1, 0, "R7");

    // R8: invalid
    setCfg(1, 4'b0001, 1, 0, "R8 E1 0001");
    fa(1, 0, "R8"); fa(1, 0, "R8"); fa(1, 0, "R8");
    setCfg(0, 4'b1100, 1, 0, "R8 T1 1100");
    fb(1, 0, "R8"); fb(1, 0, "R8");

    // R9: config change clears and suppresses
    setCfg(0, 4'b0001, 0, 1, "R9 cfg");
    fb(1, 0, "R9");
    nextCode = 4'b0010;
    fb(1, 0, "R9 change suppresses");
    fb(1, 0, "R9 history cleared");
    fb(1, 1, "R9 declare");

    idle("end"); idle("end");
    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule